// File: doc/BRIEF.md
# USB PHY Control Register Bank

This block is the 32-bit software-visible register file of a USB PHY control unit. It answers a single-cycle word-addressed read/write request bus. Most of its registers expose four consecutive word addresses: a plain storage address and three bit-manipulation aliases. A write of ones through an alias sets, clears or inverts the matching bits of the stored word. A read from any of the four addresses returns the stored word.

The control register carries a self-reset bit in position 31. Driving that bit through the control word's plain or set address reloads the power-down, transmit, receive and control registers with their preset values. Through the invert alias, the reload happens only if the inversion leaves bit 31 at one. All other registers keep their contents. The synchronous hardware reset loads every register, and two words are constants that discard writes. Read data is registered and appears one cycle after the request, together with a valid strobe.

Top module: `phy_ctl_regbank`

## Requirements
- R1: After hardware reset the registers read: power-down (index 0) 0x001E1C00, transmit (4) 0x10060607, receive (8) 0x00000000, control (12) 0xC0200000, status (16) 0x00000000, debug (0x14) 0x7F180000, debug status (0x18) 0x00000000, second debug (0x1C) 0x00001000, revision (0x20) 0x04020000.
- R2: The grouped registers sit at base indices 0, 4, 8, 12, 0x14 and 0x1C. Index base+1 is the set alias, base+2 the clear alias and base+3 the invert alias. A read of any alias returns the base register's value. A read of an index that maps to no register, including everything above 0x20, returns 0.
- R3: A write to a base index stores the write data unchanged.
- R4: A write to a set alias ORs the data into the base register.
- R5: A write to a clear alias clears every base-register bit that is 1 in the data.
- R6: A write to an invert alias XORs the data into the base register.
- R7: A write to index 12 or 13 with data bit 31 at 1 loads power-down, transmit, receive and control with their reset values (R1). The reload takes precedence over the write, so control reads 0xC0200000. Status and the debug registers keep their contents.
- R8: A write to index 15 with data bit 31 at 1 performs the self-reset of R7 only if control bit 31 was 0 before the write. Otherwise it only inverts the bits.
- R9: A write to index 14 never performs the self-reset. It only clears bits.
- R10: Status is writable only at index 16. Indices 0x11 to 0x13 ignore writes and read 0.
- R11: Debug status (0x18), revision (0x20) and every unmapped index ignore writes.
- R12: `rd_valid` is high in the cycle after each read request and carries the read data. It stays low after a write request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | ADDR_W | Word index of the access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |

## Verification
The bound checker examines, on every cycle:
- the revision value and the zero data returned for reads above the map;
- the self-reset outcome of a plain control write with bit 31 set;
- the fact that a control clear leaves power-down untouched;
- that set-alias writes land in the transmit register;
- the read-strobe timing.

The bench sweeps every operation on every grouped register with several patterns and reads all four aliases after each write. It re-reads the full index map after reset, after the self-reset cases and after writes to read-only and unmapped indices. These scenarios cover what a per-cycle property cannot show: the conditional invert-alias self-reset that depends on history, the survival of non-reset registers, and the full map contents.

// File: rtl/phy_regbank_pkg.sv
package phy_regbank_pkg;

    localparam int DATA_W   = 32;
    localparam int NREG     = 9;
    localparam int SOFT_BIT = 31;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_WR  = 2'd0,
        OP_SET = 2'd1,
        OP_CLR = 2'd2,
        OP_TOG = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        RG_PWR   = 4'd0,
        RG_TXC   = 4'd1,
        RG_RXC   = 4'd2,
        RG_CTL   = 4'd3,
        RG_STS   = 4'd4,
        RG_DBG   = 4'd5,
        RG_DBGST = 4'd6,
        RG_DBG2  = 4'd7,
        RG_REV   = 4'd8
    } reg_e;

    // Registers that accept writes, and registers reloaded by self-reset.
    localparam logic [NREG-1:0] WR_MASK   = 9'b0_1011_1111;
    localparam logic [NREG-1:0] SOFT_MASK = 9'b0_0000_1111;

    typedef struct packed {
        logic hit;
        logic wr_ok;
        reg_e id;
        op_e  op;
    } acc_t;

    // Hardware reset value; for self-reset members it equals the reload value.
    function automatic word_t reset_value(int r);
        case (r)
            0:       return 32'h001E_1C00;
            1:       return 32'h1006_0607;
            3:       return 32'hC020_0000;
            5:       return 32'h7F18_0000;
            7:       return 32'h0000_1000;
            8:       return 32'h0402_0000;
            default: return 32'h0000_0000;
        endcase
    endfunction

    function automatic word_t apply_op(op_e op, word_t cur, word_t d);
        case (op)
            OP_SET:  return cur | d;
            OP_CLR:  return cur & ~d;
            OP_TOG:  return cur ^ d;
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/phy_regbank_decode.sv
module phy_regbank_decode
    import phy_regbank_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] index,
    output acc_t              acc
);
    localparam int GRP_W = ADDR_W - 2;

    logic [GRP_W-1:0] grp;
    logic [1:0]       sub;

    assign grp = index[ADDR_W-1:2];
    assign sub = index[1:0];

    always_comb begin
        acc.hit   = 1'b0;
        acc.wr_ok = 1'b0;
        acc.id    = RG_PWR;
        acc.op    = OP_WR;
        case (int'(grp))
            0, 1, 2, 3, 5, 7: begin
                acc.hit   = 1'b1;
                acc.wr_ok = 1'b1;
                acc.id    = reg_e'(4'(int'(grp)));
                acc.op    = op_e'(sub);
            end
            4: if (sub == 2'd0) begin
                acc.hit   = 1'b1;
                acc.wr_ok = 1'b1;
                acc.id    = RG_STS;
            end
            6: if (sub == 2'd0) begin
                acc.hit = 1'b1;
                acc.id  = RG_DBGST;
            end
            8: if (sub == 2'd0) begin
                acc.hit = 1'b1;
                acc.id  = RG_REV;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/phy_regbank_word.sv
module phy_regbank_word
    import phy_regbank_pkg::*;
#(
    parameter word_t HW_VAL  = '0,
    parameter bit    SOFT_EN = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  soft_rst,
    input  logic  wr_en,
    input  op_e   op,
    input  word_t wdata,
    output word_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= HW_VAL;
        else if (SOFT_EN && soft_rst)
            q <= HW_VAL;
        else if (wr_en)
            q <= apply_op(op, q, wdata);
    end
endmodule

// File: rtl/phy_regbank_rdmux.sv
module phy_regbank_rdmux
    import phy_regbank_pkg::*;
(
    input  acc_t                   acc,
    input  logic [NREG-1:0][31:0]  regs,
    output word_t                  rdata
);
    always_comb begin
        rdata = '0;
        if (acc.hit)
            rdata = regs[acc.id];
    end
endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
    import phy_regbank_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_index,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    output logic              rd_valid
);
    acc_t                  acc;
    logic [NREG-1:0][31:0] regs_q;
    logic                  wr_fire;
    logic                  soft_fire;
    word_t                 rd_next;

    phy_regbank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .index (req_index),
        .acc   (acc)
    );

    assign wr_fire = req_valid && req_write && acc.hit && acc.wr_ok;

    // Self-reset: plain or set write with bit 31; invert only if it leaves bit 31 high.
    always_comb begin
        soft_fire = 1'b0;
        if (wr_fire && acc.id == RG_CTL && req_wdata[SOFT_BIT]) begin
            case (acc.op)
                OP_WR, OP_SET: soft_fire = 1'b1;
                OP_TOG:        soft_fire = !regs_q[RG_CTL][SOFT_BIT];
                default:       soft_fire = 1'b0;
            endcase
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (WR_MASK[i]) begin : g_rw
            phy_regbank_word #(
                .HW_VAL  (reset_value(i)),
                .SOFT_EN (SOFT_MASK[i])
            ) u_word (
                .clk      (clk),
                .rst      (rst),
                .soft_rst (soft_fire),
                .wr_en    (wr_fire && (int'(acc.id) == i)),
                .op       (acc.op),
                .wdata    (req_wdata),
                .q        (regs_q[i])
            );
        end else begin : g_ro
            assign regs_q[i] = reset_value(i);
        end
    end

    phy_regbank_rdmux u_rdmux (
        .acc   (acc),
        .regs  (regs_q),
        .rdata (rd_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= req_valid && !req_write;
            if (req_valid && !req_write)
                rd_data <= rd_next;
        end
    end
endmodule

// File: rtl/phy_regbank_chk.sv
module phy_regbank_chk
    import phy_regbank_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_write,
    input logic [ADDR_W-1:0]     req_index,
    input logic [31:0]           req_wdata,
    input logic [31:0]           rd_data,
    input logic                  rd_valid,
    input logic [NREG-1:0][31:0] regs_q
);
    logic rd_req, wr_req;
    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid && req_write;

    p_rev_read_r11: assert property (@(posedge clk) disable iff (rst)
        rd_req && req_index == ADDR_W'(32) |=> rd_data == 32'h0402_0000);

    p_beyond_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_req && req_index > ADDR_W'(32) |=> rd_data == 32'h0);

    p_soft_base_r7: assert property (@(posedge clk) disable iff (rst)
        wr_req && req_index == ADDR_W'(12) && req_wdata[31]
        |=> regs_q[RG_CTL] == 32'hC020_0000 && regs_q[RG_PWR] == 32'h001E_1C00);

    p_clr_nosoft_r9: assert property (@(posedge clk) disable iff (rst)
        wr_req && req_index == ADDR_W'(14)
        |=> regs_q[RG_PWR] == $past(regs_q[RG_PWR]));

    p_set_covers_r4: assert property (@(posedge clk) disable iff (rst)
        wr_req && req_index == ADDR_W'(5)
        |=> (regs_q[RG_TXC] & $past(req_wdata)) == $past(req_wdata));

    p_wr_noread_r12: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> !rd_valid);

    p_rd_strobe_r12: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);
endmodule

bind phy_ctl_regbank phy_regbank_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_index (req_index),
    .req_wdata (req_wdata),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .regs_q    (regs_q)
);

// File: tb/test_phy_ctl_regbank.sv
`timescale 1ns/1ps
module test_phy_ctl_regbank;
    localparam int ADDR_W = 6;
    localparam int NIDX   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_index = '0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       rd_data;
    logic              rd_valid;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] mdl [9];

    always #2 clk = ~clk;

    phy_ctl_regbank #(.ADDR_W(ADDR_W)) i_phy_ctl_regbank (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_index(req_index), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(string tag, int idx, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s index 0x%0h: actual 0x%08h expected 0x%08h", tag, idx, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Model built from the requirements.
    task automatic model_reset();
        mdl[0] = 32'h001E_1C00; mdl[1] = 32'h1006_0607; mdl[2] = 32'h0;
        mdl[3] = 32'hC020_0000; mdl[4] = 32'h0;         mdl[5] = 32'h7F18_0000;
        mdl[6] = 32'h0;         mdl[7] = 32'h0000_1000; mdl[8] = 32'h0402_0000;
    endtask

    function automatic int grp_reg(int idx);
        case (idx / 4)
            0, 1, 2, 3, 5, 7: return idx / 4;
            default:          return -1;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(int idx);
        int r = grp_reg(idx);
        if (r >= 0)       return mdl[r];
        if (idx == 16)    return mdl[4];
        if (idx == 'h18)  return mdl[6];
        if (idx == 'h20)  return mdl[8];
        return 32'h0;
    endfunction

    task automatic model_write(int idx, logic [31:0] d);
        int r = grp_reg(idx);
        if (r >= 0) begin
            int op = idx % 4;
            logic [31:0] nv;
            case (op)
                0: nv = d;
                1: nv = mdl[r] | d;
                2: nv = mdl[r] & ~d;
                default: nv = mdl[r] ^ d;
            endcase
            mdl[r] = nv;
            if (r == 3 && d[31] && (op == 0 || op == 1 || (op == 3 && nv[31]))) begin
                mdl[0] = 32'h001E_1C00; mdl[1] = 32'h1006_0607;
                mdl[2] = 32'h0;         mdl[3] = 32'hC020_0000;
            end
        end else if (idx == 16) begin
            mdl[4] = d;
        end
    endtask

    task automatic do_write(int idx, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_index = ADDR_W'(idx); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R12 rd_valid after write", idx, {31'b0, rd_valid}, 32'h0);
        model_write(idx, d);
    endtask

    task automatic do_read(int idx, output logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_index = ADDR_W'(idx);
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 rd_valid after read", idx, {31'b0, rd_valid}, 32'h1);
        v = rd_data;
    endtask

    task automatic read_check(string tag, int idx);
        logic [31:0] v;
        do_read(idx, v);
        check(tag, idx, v, exp_read(idx));
    endtask

    task automatic full_map(string tag);
        for (int i = 0; i < NIDX; i++) read_check(tag, i);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pats [3];
        int bases [6];
        string optag [4];
        pats[0] = 32'hA5A5_5A5A; pats[1] = 32'hFFFF_0000; pats[2] = 32'h0F0F_3C3C;
        bases[0] = 0; bases[1] = 4; bases[2] = 8; bases[3] = 12; bases[4] = 'h14; bases[5] = 'h1C;
        optag[0] = "R3"; optag[1] = "R4"; optag[2] = "R5"; optag[3] = "R6";

        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R12 rd_valid in reset state", 0, {31'b0, rd_valid}, 32'h0);
        check("R1 rd_data in reset state", 0, rd_data, 32'h0);

        // R1 / R2: whole map after hardware reset
        full_map("R1 reset map (R2 aliases and unmapped)");

        // R3..R6 sweep: each op on each grouped register, all aliases read back (R2)
        for (int p = 0; p < 3; p++)
            for (int b = 0; b < 6; b++)
                for (int op = 0; op < 4; op++) begin
                    do_write(bases[b] + op, pats[p]);
                    for (int a = 0; a < 4; a++) read_check(optag[op], bases[b] + a);
                end

        // R7: plain control write with bit 31
        do_write(0, 32'h0); do_write(4, 32'h0); do_write(8, 32'hFFFF_FFFF);
        do_write(16, 32'h1234_5678); do_write('h14, 32'h0000_00AA); do_write('h1C, 32'h5555_0000);
        do_write(12, 32'h8000_0001);
        do_read(12, v); check("R7 control after self-reset", 12, v, 32'hC020_0000);
        do_read(8, v);  check("R7 receive reloaded", 8, v, 32'h0);
        do_read(16, v); check("R7 status kept", 16, v, 32'h1234_5678);
        full_map("R7 map after base self-reset");

        // R7: set alias with bit 31
        do_write(0, 32'h0); do_write(12, 32'h0000_0003);
        do_write(13, 32'h8000_0000);
        do_read(0, v); check("R7 set alias reload", 0, v, 32'h001E_1C00);
        full_map("R7 map after set-alias self-reset");

        // R9: clear alias never reloads
        do_write(0, 32'h0000_0011);
        do_write(14, 32'h8000_0000);
        do_read(0, v);  check("R9 clear keeps power-down", 0, v, 32'h0000_0011);
        do_read(12, v); check("R9 clear drops bit 31", 12, v, 32'h4020_0000);

        // R8: invert with bit 31 previously 0 -> reload
        do_write(15, 32'h8000_0000);
        do_read(0, v);  check("R8 invert to one reloads", 0, v, 32'h001E_1C00);
        do_read(12, v); check("R8 control after reload", 12, v, 32'hC020_0000);
        // R8: invert with bit 31 previously 1 -> no reload
        do_write(4, 32'h0000_0022);
        do_write(15, 32'h8000_0001);
        do_read(4, v);  check("R8 invert to zero keeps transmit", 4, v, 32'h0000_0022);
        do_read(12, v); check("R8 invert result", 12, v, 32'h4020_0001);
        full_map("R8 map after invert cases");

        // R10: status writable only at its base
        do_write(16, 32'hDEAD_BEEF);
        for (int i = 'h11; i <= 'h13; i++) do_write(i, 32'hFFFF_FFFF);
        do_read(16, v); check("R10 status base write", 16, v, 32'hDEAD_BEEF);
        for (int i = 'h11; i <= 'h13; i++) begin
            do_read(i, v); check("R10 status alias reads zero", i, v, 32'h0);
        end

        // R11: read-only and unmapped indices ignore writes
        do_write('h18, 32'hFFFF_FFFF);
        for (int i = 'h19; i <= 'h1B; i++) do_write(i, 32'hFFFF_FFFF);
        for (int i = 'h20; i < NIDX; i++) do_write(i, 32'hFFFF_FFFF);
        do_read('h18, v); check("R11 debug status unchanged", 'h18, v, 32'h0);
        do_read('h20, v); check("R11 revision unchanged", 'h20, v, 32'h0402_0000);
        full_map("R11 map after read-only writes");

        summary();
    end
endmodule